// File: doc/BRIEF.md
# Memory-Mapped ATA Task-File Bridge

This block connects a big-endian host bus to an ATA task-file register set. A host access carries an address, a size code and, for writes, data. The block takes the register slot from a 4 KB window in which registers sit 16 bytes apart. It then sends the access to one of two downstream ports. The first is a byte-wide task-file port with a register number and read/write strobes. The second is a data port, 16 or 32 bits wide, that carries the drive's sector data.

The slot decode is sparse. Byte accesses reach the seven command-block registers. Two slots alias the control register for writes and the alternate-status register for reads. Halfword and word accesses reach only the data register, and their byte order is reversed in both directions so that a little-endian drive appears in host order. Every other slot reads as all ones and drops writes.

The host accepts a request on valid while ready is high. Read data is registered and returned with a valid pulse on the next cycle. Downstream strobes are combinational in the request cycle, and the downstream read data is sampled in that same cycle.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The slot index is address bits [11:4]. Address bits above 11 and below 4 have no effect on the decode.
- R2: A byte access (size code 0) at index 1 to 7 raises the task-file read or write strobe with register number equal to the index. Write data goes out on tf_wdata_o from bits [7:0]. Read data returns in bits [7:0] with bits [31:8] zero.
- R3: A byte access at index 8 or 22 uses task-file register number 8. A write there is the device-control write and a read there is the alternate-status read.
- R4: A byte access at any other index, index 0 included, raises no strobe. A read there returns 0x000000FF.
- R5: Halfword (size code 1) and word (size code 2) accesses at index 0 raise the data-port strobe. At any other index they raise no strobe and read 0x0000FFFF or 0xFFFFFFFF. Size code 3 raises no strobe and reads 0xFFFFFFFF.
- R6: A halfword data access drives dp_wide_o low and swaps the two bytes of bits [15:0] in both directions. Bits [31:16] are zero on the data written to the data port and on the data returned to the host.
- R7: A word data access drives dp_wide_o high and reverses all four bytes in both directions.
- R8: An accepted read yields rsp_valid_o high with its data on the next cycle only. An accepted write yields no response.
- R9: While rst_ni is low, req_ready_o, rsp_valid_o, rsp_rdata_o and all downstream strobes are low or zero, whatever req_valid_i does. Ready rises at the first clock edge after reset is released.
- R10: At most one of the four downstream strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Bridge can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr_i | input | 16 | Host byte address |
| req_wdata_i | input | 32 | Write data, right aligned |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data, right aligned |
| tf_reg_o | output | 4 | Task-file register number (1-7, 8 = control/alt-status) |
| tf_wr_o | output | 1 | Task-file write strobe |
| tf_rd_o | output | 1 | Task-file read strobe |
| tf_wdata_o | output | 8 | Task-file write data |
| tf_rdata_i | input | 8 | Task-file read data, valid in the strobe cycle |
| dp_wr_o | output | 1 | Data-port write strobe |
| dp_rd_o | output | 1 | Data-port read strobe |
| dp_wide_o | output | 1 | Data-port width, 1 = 32 bit, 0 = 16 bit |
| dp_wdata_o | output | 32 | Data-port write data, drive byte order |
| dp_rdata_i | input | 32 | Data-port read data, drive byte order |

## Verification
The assertions assume that the task-file and data-port read data settle within the strobe cycle. They also assume the host holds a request stable only for the cycle in which it is accepted. The stimulus issues one request at a time: it drives the request after a falling edge and withdraws it after the next rising edge. A combinational drive model answers every strobe at once. Every register slot class, every size code and the aliased slots are covered, along with addresses that carry stray upper and lower bits. Requests are also held high during reset to show that they are ignored.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TF   = 2'd1,
    TGT_DATA = 2'd2
  } target_e;

  localparam int unsigned CTRL_REG_NUM = 8;
endpackage

// File: rtl/ata_bridge_decode.sv
module ata_bridge_decode
  import ata_bridge_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned WIN_MSB  = 11,
  parameter int unsigned IDX_LSB  = 4,
  parameter int unsigned TF_LAST  = 7,
  parameter int unsigned ALIAS_A  = 8,
  parameter int unsigned ALIAS_B  = 22,
  parameter int unsigned REG_W    = 4
) (
  input  logic [AW-1:0]    addr_i,
  input  acc_size_e        size_i,
  output target_e          tgt_o,
  output logic [REG_W-1:0] tf_reg_o
);
  localparam int unsigned IDX_W = WIN_MSB - IDX_LSB + 1;

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[WIN_MSB:IDX_LSB];

  always_comb begin
    tgt_o    = TGT_NONE;
    tf_reg_o = '0;
    unique case (size_i)
      SZ_BYTE: begin
        if (idx >= IDX_W'(1) && idx <= IDX_W'(TF_LAST)) begin
          tgt_o    = TGT_TF;
          tf_reg_o = idx[REG_W-1:0];
        end else if (idx == IDX_W'(ALIAS_A) || idx == IDX_W'(ALIAS_B)) begin
          tgt_o    = TGT_TF;
          tf_reg_o = REG_W'(CTRL_REG_NUM);
        end
      end
      SZ_HALF, SZ_WORD: begin
        if (idx == '0) tgt_o = TGT_DATA;
      end
      default: tgt_o = TGT_NONE;
    endcase
  end

  always_comb begin
    AST_TF_REG_RANGE: assert (tgt_o != TGT_TF ||
      (tf_reg_o >= REG_W'(1) && tf_reg_o <= REG_W'(CTRL_REG_NUM))); // R2
    AST_DATA_ONLY_WIDE: assert (tgt_o != TGT_DATA || size_i != SZ_BYTE); // R5
  end
endmodule

// File: rtl/ata_bridge_swap.sv
module ata_bridge_swap #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] din_i,
  input  logic          wide_i,
  output logic [DW-1:0] dout_o
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] rev_full;
  logic [DW-1:0] rev_half;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign rev_full[8*b +: 8] = din_i[8*(NB-1-b) +: 8];
  end

  assign rev_half = {{(DW-16){1'b0}}, din_i[7:0], din_i[15:8]};
  assign dout_o   = wide_i ? rev_full : rev_half;
endmodule

// File: rtl/mmio_ata_bridge.sv
module mmio_ata_bridge
  import ata_bridge_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned REG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [1:0]       req_size_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             rsp_valid_o,
  output logic [DW-1:0]    rsp_rdata_o,
  output logic [REG_W-1:0] tf_reg_o,
  output logic             tf_wr_o,
  output logic             tf_rd_o,
  output logic [7:0]       tf_wdata_o,
  input  logic [7:0]       tf_rdata_i,
  output logic             dp_wr_o,
  output logic             dp_rd_o,
  output logic             dp_wide_o,
  output logic [DW-1:0]    dp_wdata_o,
  input  logic [DW-1:0]    dp_rdata_i
);
  acc_size_e  size;
  target_e    tgt;
  logic       run_q;
  logic       fire;
  logic       wide;
  logic [DW-1:0] rd_swapped;
  logic [DW-1:0] rd_mux;

  assign size = acc_size_e'(req_size_i);

  ata_bridge_decode #(.AW(AW), .REG_W(REG_W)) u_decode (
    .addr_i  (req_addr_i),
    .size_i  (size),
    .tgt_o   (tgt),
    .tf_reg_o(tf_reg_o)
  );

  ata_bridge_swap #(.DW(DW)) u_swap_wr (
    .din_i (req_wdata_i),
    .wide_i(wide),
    .dout_o(dp_wdata_o)
  );

  ata_bridge_swap #(.DW(DW)) u_swap_rd (
    .din_i (dp_rdata_i),
    .wide_i(wide),
    .dout_o(rd_swapped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign req_ready_o = run_q;
  assign fire        = req_valid_i & run_q;
  assign wide        = (size == SZ_WORD);
  assign dp_wide_o   = wide;
  assign tf_wdata_o  = req_wdata_i[7:0];

  assign tf_wr_o = fire &  req_write_i & (tgt == TGT_TF);
  assign tf_rd_o = fire & ~req_write_i & (tgt == TGT_TF);
  assign dp_wr_o = fire &  req_write_i & (tgt == TGT_DATA);
  assign dp_rd_o = fire & ~req_write_i & (tgt == TGT_DATA);

  always_comb begin
    unique case (tgt)
      TGT_TF:   rd_mux = {{(DW-8){1'b0}}, tf_rdata_i};
      TGT_DATA: rd_mux = rd_swapped;
      default: begin
        unique case (size)
          SZ_BYTE: rd_mux = {{(DW-8){1'b0}},  8'hFF};
          SZ_HALF: rd_mux = {{(DW-16){1'b0}}, 16'hFFFF};
          default: rd_mux = '1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= fire & ~req_write_i;
      if (fire & ~req_write_i) rsp_rdata_o <= rd_mux;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tf_wr_o, tf_rd_o, dp_wr_o, dp_rd_o}) <= 1); // R10
  AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_write_i) |=> rsp_valid_o); // R8
  AST_NO_RSP_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_valid_i && req_ready_o) || req_write_i) |=> !rsp_valid_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(tf_wr_o || tf_rd_o || dp_wr_o || dp_rd_o)); // R9
  AST_RSP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |=> (rsp_valid_o || $stable(rsp_rdata_o))); // R8
endmodule

// File: tb/tb_mmio_ata_bridge.sv
module tb_mmio_ata_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_size_i = 2'd0;
  logic [15:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [3:0]  tf_reg_o;
  logic        tf_wr_o, tf_rd_o;
  logic [7:0]  tf_wdata_o;
  logic [7:0]  tf_rdata_i;
  logic        dp_wr_o, dp_rd_o, dp_wide_o;
  logic [31:0] dp_wdata_o;
  logic [31:0] dp_rdata_i;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  // drive model: register n reads as 0xA0|n, data port fixed
  assign tf_rdata_i = 8'hA0 | {4'h0, tf_reg_o};
  assign dp_rdata_i = 32'h11223344;

  mmio_ata_bridge dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // strobe vector order: {tf_wr, tf_rd, dp_wr, dp_rd}
  task automatic do_rd(logic [15:0] a, logic [1:0] s, logic [31:0] exp,
                       logic [3:0] exp_str, logic [3:0] exp_reg, string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_size_i = s; req_addr_i = a;
    #1;
    check({tag, " strobes"}, {28'h0, tf_wr_o, tf_rd_o, dp_wr_o, dp_rd_o}, {28'h0, exp_str});
    if (exp_str[2]) check({tag, " reg"}, {28'h0, tf_reg_o}, {28'h0, exp_reg});
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic do_wr(logic [15:0] a, logic [1:0] s, logic [31:0] d,
                       logic [3:0] exp_str, logic [3:0] exp_reg,
                       logic [31:0] exp_dp, logic exp_wide, string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_size_i = s; req_addr_i = a;
    req_wdata_i = d;
    #1;
    check({tag, " strobes"}, {28'h0, tf_wr_o, tf_rd_o, dp_wr_o, dp_rd_o}, {28'h0, exp_str});
    if (exp_str[3]) begin
      check({tag, " reg"}, {28'h0, tf_reg_o}, {28'h0, exp_reg});
      check({tag, " tf data"}, {24'h0, tf_wdata_o}, {24'h0, d[7:0]});
    end
    if (exp_str[1]) begin
      check({tag, " dp data"}, dp_wdata_o, exp_dp);
      check({tag, " width"}, {31'h0, dp_wide_o}, {31'h0, exp_wide});
    end
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    check({tag, " R8 no response"}, {31'h0, rsp_valid_o}, 32'h0);
  endtask

  // monitor: pops the scoreboard on every response
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected response", rsp_rdata_o, 32'hxxxxxxxx);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, rsp_rdata_o, e);
        end
      end
    end
  end

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R9: request held during reset is ignored
    req_valid_i = 1'b1; req_size_i = 2'd0; req_addr_i = 16'h0010;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R9 ready in reset", {31'h0, req_ready_o}, 32'h0);
    check("R9 strobes in reset", {28'h0, tf_wr_o, tf_rd_o, dp_wr_o, dp_rd_o}, 32'h0);
    check("R9 rsp_valid in reset", {31'h0, rsp_valid_o}, 32'h0);
    check("R9 rdata in reset", rsp_rdata_o, 32'h0);
    req_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R9 ready after reset", {31'h0, req_ready_o}, 32'h1);

    // R2 task-file reads 1..7
    for (int k = 1; k <= 7; k++)
      do_rd(16'(k << 4), 2'd0, {24'h0, 8'hA0 | 8'(k)}, 4'b0100, 4'(k), "R2 tf read");
    // R1 stray bits above 11 and below 4
    do_rd(16'hF03F, 2'd0, 32'h000000A3, 4'b0100, 4'd3, "R1 stray addr bits");
    // R3 aliased alternate status
    do_rd(16'h0080, 2'd0, 32'h000000A8, 4'b0100, 4'd8, "R3 alt status idx8");
    do_rd(16'h0160, 2'd0, 32'h000000A8, 4'b0100, 4'd8, "R3 alt status idx22");
    // R4 unmapped byte slots
    do_rd(16'h0000, 2'd0, 32'h000000FF, 4'b0000, 4'd0, "R4 byte idx0");
    do_rd(16'h0090, 2'd0, 32'h000000FF, 4'b0000, 4'd0, "R4 byte idx9");
    do_rd(16'h0FF0, 2'd0, 32'h000000FF, 4'b0000, 4'd0, "R4 byte idx255");
    // R6, R7 data reads
    do_rd(16'h0000, 2'd1, 32'h00004433, 4'b0001, 4'd0, "R6 half read");
    do_rd(16'h300C, 2'd2, 32'h44332211, 4'b0001, 4'd0, "R7 word read stray bits");
    // R5 unmapped wide slots and reserved size
    do_rd(16'h0030, 2'd1, 32'h0000FFFF, 4'b0000, 4'd0, "R5 half idx3");
    do_rd(16'h0010, 2'd2, 32'hFFFFFFFF, 4'b0000, 4'd0, "R5 word idx1");
    do_rd(16'h0000, 2'd3, 32'hFFFFFFFF, 4'b0000, 4'd0, "R5 reserved size");

    // writes
    do_wr(16'h0050, 2'd0, 32'hCAFE005A, 4'b1000, 4'd5, 32'h0, 1'b0, "R2 tf write");
    do_wr(16'h0080, 2'd0, 32'h00000006, 4'b1000, 4'd8, 32'h0, 1'b0, "R3 ctrl write idx8");
    do_wr(16'h0160, 2'd0, 32'h00000002, 4'b1000, 4'd8, 32'h0, 1'b0, "R3 ctrl write idx22");
    do_wr(16'h0000, 2'd0, 32'h00000011, 4'b0000, 4'd0, 32'h0, 1'b0, "R4 byte write idx0");
    do_wr(16'h00A0, 2'd0, 32'h00000011, 4'b0000, 4'd0, 32'h0, 1'b0, "R4 byte write idx10");
    do_wr(16'h0000, 2'd1, 32'h0000BEEF, 4'b0010, 4'd0, 32'h0000EFBE, 1'b0, "R6 half write");
    do_wr(16'h0000, 2'd1, 32'hABCDBEEF, 4'b0010, 4'd0, 32'h0000EFBE, 1'b0, "R6 half write upper");
    do_wr(16'h0000, 2'd2, 32'h12345678, 4'b0010, 4'd0, 32'h78563412, 1'b1, "R7 word write");
    do_wr(16'h0020, 2'd1, 32'h0000BEEF, 4'b0000, 4'd0, 32'h0, 1'b0, "R5 half write idx2");
    do_wr(16'h0000, 2'd3, 32'h12345678, 4'b0000, 4'd0, 32'h0, 1'b0, "R5 reserved write");

    // R10 back-to-back mixed: checked by strobe vectors above and assertion
    repeat (3) @(negedge clk_i);
    check("R8 all responses seen", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule